// File: doc/BRIEF.md
# Four-Channel Byte DMA Controller

This block moves single bytes between peripherals and memory on behalf of a host. Each of its four channels holds a 16-bit memory address and a 16-bit transfer count, each with a base copy and a working copy. A peripheral asks for service by raising its request line. The controller grants one channel at a time. For that channel it presents an acknowledge, the working address and a pair of read/write strobes: one strobe for the memory side and the opposite one for the I/O side. It then steps the address and the count. When the count runs out, or when the external end-of-process input is pulled low, the terminal-count output and status flag tell the peripheral and the host that the transfer is over. The channel then either masks itself or reloads its working registers from the base copies so that the same transfer runs again.

Channels 0 and 1 can also copy a block from memory to memory. Each byte takes two cycles. In the first, the byte at channel 0's address is read into an internal 8-bit holding register. In the second, that byte is written to channel 1's address. Channel 1's count sets the length of the copy. The host programs the controller through a small register port. On that port it writes addresses, counts, per-channel mode bits, the mask and the copy enable, and it reads back working values and the status flags.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset no acknowledge or strobe is active, the mask register (address 12, bits 3:0, one bit per channel) reads 0xF and the status register (address 14, bits 3:0) reads 0.
- R2: Channel c's address register is at host address 2c and its count register at 2c+1. A write loads the base and working copies together. A read returns the working copy.
- R3: Each granted request yields exactly one acknowledge cycle on dack[c], starting the cycle after the request is sampled. In that cycle mem_addr is the working address. With mode bit 2 set (mode register at address 8+c), io_rd and mem_wr are high. With mode bit 2 clear, mem_rd and io_wr are high.
- R4: After each byte the working count drops by one. The working address rises by one, or falls by one when mode bit 0 is set.
- R5: A count value N yields N+1 bytes. tc is high during the byte whose working count is 0. After that byte, status bit c is set and, unless auto-initialize is on, mask bit c is set.
- R6: With mode bit 1 (auto-initialize) set, the end of a transfer copies the base address and base count into the working registers and leaves the mask bit clear.
- R7: eop_n low during a transfer cycle ends the transfer after that byte, as terminal count does: status bit set, mask set or reload, and the byte still counted. tc stays low unless the count is 0.
- R8: Among unmasked pending requests, the lowest-numbered channel wins, and at most one acknowledge is active.
- R9: With control bit 0 (address 13) set and mask bit 0 clear, the block copies memory to memory. A read cycle at channel 0's address is followed by a write cycle of the held byte at channel 1's address, with no acknowledge. Both addresses step by their own mode bit 0. Channel 1's count runs the copy for count+1 bytes, and tc is high on the last write. At the end, status bit 1 is set and mask bit 0 is set. In this mode drq[0] and drq[1] are not served as peripheral requests.
- R10: A status read clears all status flags, but a flag set in the same cycle as the read survives.
- R11: A request on a masked channel is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (clears status on address 14) |
| reg_addr | input | 4 | Host register address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data, combinational from reg_addr |
| drq | input | 4 | Per-channel service requests |
| dack | output | 4 | Per-channel acknowledges, one-hot or zero |
| eop_n | input | 1 | Active-low external end of process |
| tc | output | 1 | Terminal count, high during the last byte |
| mem_addr | output | 16 | Memory address of the current cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| mem_rdata | input | 8 | Memory read data for memory-to-memory copies |
| mem_wdata | output | 8 | Holding register driven as memory write data |

## Verification
A host status read and a terminal-count byte can fall on the same clock edge: the read clears the flags while the final byte tries to set one. The bench arranges this by raising a one-byte request on a channel and asserting the status read exactly in the acknowledge cycle. The value read in that cycle must still show the old flags. The next status read must show the new flag, and a third read must show it cleared, which confirms that setting takes precedence over clearing.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_MMRD = 2'd2,
        ST_MMWR = 2'd3
    } dma_st_e;

    // per-channel mode bit positions
    localparam int MB_DEC   = 0;
    localparam int MB_AUTO  = 1;
    localparam int MB_TOMEM = 2;
    localparam int MODE_W   = 3;
endpackage

// File: rtl/dma4_prio.sv
module dma4_prio #(
    parameter int N   = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        gnt = any ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/dma4_step.sv
module dma4_step #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] cnt,
    input  logic          dec,
    output logic [AW-1:0] addr_nx,
    output logic [CW-1:0] cnt_nx
);
    assign addr_nx = dec ? (addr - AW'(1)) : (addr + AW'(1));
    assign cnt_nx  = cnt - CW'(1);
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int DW  = 8,
    parameter int RAW = 4,
    parameter int RDW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [RAW-1:0] reg_addr,
    input  logic [RDW-1:0] reg_wdata,
    output logic [RDW-1:0] reg_rdata,
    input  logic [NCH-1:0] drq,
    output logic [NCH-1:0] dack,
    input  logic           eop_n,
    output logic           tc,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           io_rd,
    output logic           io_wr,
    input  logic [DW-1:0]  mem_rdata,
    output logic [DW-1:0]  mem_wdata
);
    localparam int CHW = $clog2(NCH);
    localparam logic [RAW-1:0] RA_MODE = RAW'(2 * NCH);
    localparam logic [RAW-1:0] RA_MASK = RAW'(3 * NCH);
    localparam logic [RAW-1:0] RA_CTRL = RAW'(3 * NCH + 1);
    localparam logic [RAW-1:0] RA_STAT = RAW'(3 * NCH + 2);

    typedef struct packed {
        dma_st_e                       st;
        logic [CHW-1:0]                ch;
        logic [NCH-1:0][AW-1:0]        cur_a;
        logic [NCH-1:0][AW-1:0]        base_a;
        logic [NCH-1:0][CW-1:0]        cur_c;
        logic [NCH-1:0][CW-1:0]        base_c;
        logic [NCH-1:0][MODE_W-1:0]    mode;
        logic [NCH-1:0]                mask;
        logic [NCH-1:0]                flag;
        logic                          mm_en;
        logic [DW-1:0]                 tmp;
    } state_t;

    state_t s_q, s_d;

    logic [NCH-1:0][AW-1:0] a_nx;
    logic [NCH-1:0][CW-1:0] c_nx;
    logic [NCH-1:0]         req, gnt, mm_blk;
    logic [CHW-1:0]         gidx;
    logic                   gany;
    logic                   done;
    logic [CHW-1:0]         rch;

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_step
            dma4_step #(.AW(AW), .CW(CW)) u_step (
                .addr    (s_q.cur_a[gi]),
                .cnt     (s_q.cur_c[gi]),
                .dec     (s_q.mode[gi][MB_DEC]),
                .addr_nx (a_nx[gi]),
                .cnt_nx  (c_nx[gi])
            );
        end
    endgenerate

    always_comb begin
        mm_blk      = '0;
        mm_blk[1:0] = {2{s_q.mm_en}};
        req         = drq & ~s_q.mask & ~mm_blk;
    end

    dma4_prio #(.N(NCH)) u_prio (
        .req (req),
        .gnt (gnt),
        .idx (gidx),
        .any (gany)
    );

    assign rch = reg_addr[CHW:1];

    // next-state
    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (reg_rd && reg_addr == RA_STAT) s_d.flag = '0;

        case (s_q.st)
            ST_IDLE: begin
                if (s_q.mm_en && !s_q.mask[0]) begin
                    s_d.st = ST_MMRD;
                end else if (gany) begin
                    s_d.st = ST_XFER;
                    s_d.ch = gidx;
                end
            end
            ST_XFER: begin
                done = (s_q.cur_c[s_q.ch] == '0) || !eop_n;
                s_d.cur_a[s_q.ch] = a_nx[s_q.ch];
                s_d.cur_c[s_q.ch] = c_nx[s_q.ch];
                if (done) begin
                    s_d.flag[s_q.ch] = 1'b1;
                    if (s_q.mode[s_q.ch][MB_AUTO]) begin
                        s_d.cur_a[s_q.ch] = s_q.base_a[s_q.ch];
                        s_d.cur_c[s_q.ch] = s_q.base_c[s_q.ch];
                    end else begin
                        s_d.mask[s_q.ch] = 1'b1;
                    end
                end
                s_d.st = ST_IDLE;
            end
            ST_MMRD: begin
                s_d.tmp = mem_rdata;
                s_d.st  = ST_MMWR;
            end
            default: begin
                done = (s_q.cur_c[1] == '0) || !eop_n;
                s_d.cur_a[0] = a_nx[0];
                s_d.cur_a[1] = a_nx[1];
                s_d.cur_c[1] = c_nx[1];
                s_d.st       = done ? ST_IDLE : ST_MMRD;
                if (done) begin
                    s_d.flag[1] = 1'b1;
                    if (s_q.mode[0][MB_AUTO]) begin
                        s_d.cur_a[0] = s_q.base_a[0];
                        s_d.cur_a[1] = s_q.base_a[1];
                        s_d.cur_c[1] = s_q.base_c[1];
                    end else begin
                        s_d.mask[0] = 1'b1;
                    end
                end
            end
        endcase

        // host writes take precedence over the transfer update
        if (reg_wr) begin
            if (reg_addr < RA_MODE) begin
                if (reg_addr[0]) begin
                    s_d.cur_c[rch]  = reg_wdata[CW-1:0];
                    s_d.base_c[rch] = reg_wdata[CW-1:0];
                end else begin
                    s_d.cur_a[rch]  = reg_wdata[AW-1:0];
                    s_d.base_a[rch] = reg_wdata[AW-1:0];
                end
            end else if (reg_addr < RA_MASK) begin
                s_d.mode[reg_addr[CHW-1:0]] = reg_wdata[MODE_W-1:0];
            end else if (reg_addr == RA_MASK) begin
                s_d.mask = reg_wdata[NCH-1:0];
            end else if (reg_addr == RA_CTRL) begin
                s_d.mm_en = reg_wdata[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    // outputs
    logic xfer, tomem;
    assign xfer  = (s_q.st == ST_XFER);
    assign tomem = s_q.mode[s_q.ch][MB_TOMEM];

    always_comb begin
        dack      = xfer ? (NCH'(1) << s_q.ch) : '0;
        mem_rd    = (xfer && !tomem) || (s_q.st == ST_MMRD);
        mem_wr    = (xfer && tomem) || (s_q.st == ST_MMWR);
        io_rd     = xfer && tomem;
        io_wr     = xfer && !tomem;
        mem_wdata = s_q.tmp;
        tc        = (xfer && s_q.cur_c[s_q.ch] == '0) ||
                    (s_q.st == ST_MMWR && s_q.cur_c[1] == '0);
        case (s_q.st)
            ST_XFER: mem_addr = s_q.cur_a[s_q.ch];
            ST_MMRD: mem_addr = s_q.cur_a[0];
            ST_MMWR: mem_addr = s_q.cur_a[1];
            default: mem_addr = '0;
        endcase
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr < RA_MODE) begin
            reg_rdata = reg_addr[0] ? RDW'(s_q.cur_c[rch]) : RDW'(s_q.cur_a[rch]);
        end else if (reg_addr < RA_MASK) begin
            reg_rdata = RDW'(s_q.mode[reg_addr[CHW-1:0]]);
        end else if (reg_addr == RA_MASK) begin
            reg_rdata = RDW'(s_q.mask);
        end else if (reg_addr == RA_CTRL) begin
            reg_rdata = RDW'(s_q.mm_en);
        end else if (reg_addr == RA_STAT) begin
            reg_rdata = RDW'(s_q.flag);
        end
    end
endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] drq,
    input logic [NCH-1:0] dack,
    input logic           tc,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           io_rd,
    input logic           io_wr
);
    assert_dack_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    assert_single_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dack != '0) |=> (dack == '0));

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr) && !(io_rd && io_wr));

    assert_io_with_dack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |-> (dack != '0));

    assert_dack_after_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dack != '0) |-> (($past(drq) & dack) != '0));

    assert_copy_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && dack == '0) |=> (mem_wr && dack == '0));

    assert_tc_in_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (dack != '0 || mem_wr));
endmodule

bind dma4_ctrl dma4_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .drq    (drq),
    .dack   (dack),
    .tc     (tc),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .io_rd  (io_rd),
    .io_wr  (io_wr)
);

// File: tb/dma4_ctrl_tb.sv
`timescale 1ns/100ps
module dma4_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  drq = '0;
    logic [3:0]  dack;
    logic        eop_n = 1'b1;
    logic        tc;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, io_rd, io_wr;
    logic [7:0]  mem_rdata, mem_wdata;

    logic [7:0]  mem [0:255];
    int          n_chk = 0, n_bad = 0;
    int          tc_cnt = 0, dack_cnt = 0;
    bit          ended = 1'b0;

    always #2.5 clk = ~clk;

    dma4_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .drq(drq), .dack(dack), .eop_n(eop_n), .tc(tc), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            mem[8'h10] <= 8'hA0;
            mem[8'h11] <= 8'hA1;
            mem[8'h12] <= 8'hA2;
            mem[8'h13] <= 8'hA3;
        end else if (mem_wr && dack == '0) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
        if (tc) tc_cnt <= tc_cnt + 1;
        if (dack != '0) dack_cnt <= dack_cnt + 1;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, $sformatf("reg %0d", a), 32'(v), 32'(exp));
    endtask

    // one single-byte transfer on channel c
    task automatic xfer(input string req, input int c, input bit eop, input bit stat_rd,
                        input logic [15:0] exp_a, input bit exp_tc, input bit exp_tomem);
        @(negedge clk);
        drq[c] = 1'b1; eop_n = !eop;
        @(negedge clk);
        chk(req, "dack", 32'(dack), 32'(4'b1 << c));
        chk(req, "mem_addr", 32'(mem_addr), 32'(exp_a));
        chk(req, "tc", 32'(tc), 32'(exp_tc));
        chk(req, "strobes", {28'b0, mem_rd, mem_wr, io_rd, io_wr},
            exp_tomem ? 32'b0110 : 32'b1001);
        drq[c] = 1'b0;
        if (stat_rd) begin
            reg_rd = 1'b1; reg_addr = 4'd14;
            #1 chk("R10", "status in tc cycle", 32'(reg_rdata), 32'h0);
        end
        @(negedge clk);
        reg_rd = 1'b0; eop_n = 1'b1;
    endtask

    task automatic t_reset;
        chk("R1", "dack", 32'(dack), 0);
        chk("R1", "strobes", {28'b0, mem_rd, mem_wr, io_rd, io_wr}, 0);
        rd_chk("R1", 4'd12, 16'hF);
        rd_chk("R1", 4'd14, 16'h0);
    endtask

    task automatic t_prog;
        wr(4'd0, 16'h1234);
        wr(4'd1, 16'h0003);
        rd_chk("R2", 4'd0, 16'h1234);
        rd_chk("R2", 4'd1, 16'h0003);
    endtask

    task automatic t_single;
        wr(4'd2, 16'h0040);
        wr(4'd3, 16'h0001);
        wr(4'd9, 16'h0004);
        @(negedge clk); drq[1] = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R11", "masked dack", 32'(dack), 0);
        end
        drq[1] = 1'b0;
        wr(4'd12, 16'hD);
        xfer("R3", 1, 0, 0, 16'h0040, 0, 1);
        rd_chk("R4", 4'd2, 16'h0041);
        rd_chk("R4", 4'd3, 16'h0000);
        xfer("R5", 1, 0, 0, 16'h0041, 1, 1);
        rd_chk("R5", 4'd14, 16'h2);
        rd_chk("R5", 4'd12, 16'hF);
        rd_chk("R5", 4'd3, 16'hFFFF);
    endtask

    task automatic t_auto;
        wr(4'd4, 16'h0080);
        wr(4'd5, 16'h0002);
        wr(4'd10, 16'h0001);
        wr(4'd12, 16'hB);
        xfer("R3", 2, 0, 0, 16'h0080, 0, 0);
        rd_chk("R4", 4'd4, 16'h007F);
        rd_chk("R4", 4'd5, 16'h0001);
        wr(4'd10, 16'h0003);
        xfer("R6", 2, 0, 0, 16'h007F, 0, 0);
        xfer("R6", 2, 0, 0, 16'h007E, 1, 0);
        rd_chk("R6", 4'd4, 16'h0080);
        rd_chk("R6", 4'd5, 16'h0002);
        rd_chk("R6", 4'd12, 16'hB);
        rd_chk("R6", 4'd14, 16'h4);
        rd_chk("R10", 4'd14, 16'h0);
    endtask

    task automatic t_same_cycle;
        wr(4'd5, 16'h0000);
        xfer("R10", 2, 0, 1, 16'h0080, 1, 0);
        rd_chk("R10", 4'd14, 16'h4);
        rd_chk("R10", 4'd14, 16'h0);
    endtask

    task automatic t_eop;
        wr(4'd6, 16'h0100);
        wr(4'd7, 16'h0005);
        wr(4'd11, 16'h0000);
        wr(4'd12, 16'h7);
        xfer("R7", 3, 1, 0, 16'h0100, 0, 0);
        rd_chk("R7", 4'd6, 16'h0101);
        rd_chk("R7", 4'd7, 16'h0004);
        rd_chk("R7", 4'd14, 16'h8);
        rd_chk("R7", 4'd12, 16'hF);
    endtask

    task automatic t_prio;
        wr(4'd2, 16'h0200);
        wr(4'd3, 16'h0010);
        wr(4'd4, 16'h0300);
        wr(4'd5, 16'h0010);
        wr(4'd10, 16'h0000);
        wr(4'd12, 16'h9);
        @(negedge clk); drq = 4'b0110;
        @(negedge clk);
        chk("R8", "first grant", 32'(dack), 32'b0010);
        chk("R8", "first addr", 32'(mem_addr), 32'h0200);
        drq = 4'b0100;
        @(negedge clk);
        @(negedge clk);
        chk("R8", "second grant", 32'(dack), 32'b0100);
        chk("R8", "second addr", 32'(mem_addr), 32'h0300);
        drq = 4'b0000;
        @(negedge clk);
    endtask

    task automatic t_m2m;
        rd_chk("R10", 4'd14, 16'h0);
        wr(4'd0, 16'h0010);
        wr(4'd8, 16'h0000);
        wr(4'd2, 16'h0053);
        wr(4'd3, 16'h0003);
        wr(4'd9, 16'h0001);
        wr(4'd13, 16'h0001);
        @(negedge clk);
        tc_cnt = 0; dack_cnt = 0;
        wr(4'd12, 16'hE);
        repeat (12) @(negedge clk);
        chk("R9", "mem 53", 32'(mem[8'h53]), 32'hA0);
        chk("R9", "mem 52", 32'(mem[8'h52]), 32'hA1);
        chk("R9", "mem 51", 32'(mem[8'h51]), 32'hA2);
        chk("R9", "mem 50", 32'(mem[8'h50]), 32'hA3);
        chk("R9", "tc pulses", 32'(tc_cnt), 1);
        chk("R9", "no dack", 32'(dack_cnt), 0);
        rd_chk("R9", 4'd14, 16'h2);
        rd_chk("R9", 4'd12, 16'hF);
        rd_chk("R9", 4'd0, 16'h0014);
        rd_chk("R9", 4'd2, 16'h004F);
        rd_chk("R9", 4'd3, 16'hFFFF);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prog();
        t_single();
        t_auto();
        t_same_cycle();
        t_eop();
        t_prio();
        t_m2m();
        finish_run();
    end
endmodule